// File: doc/BRIEF.md
# Shadow-Locked PWM Channel

This block generates one pulse-width-modulated output from a clock-cycle counter. Software programs a 32-bit period and a 32-bit duty count through a small register bus with a write strobe and a combinational read port. The channel runs either continuously or as a counted burst of 1 to 256 periods. The output can be left-aligned or centre-aligned, and software chooses the level used during the duty portion and the level held while the channel is stopped. An optional divider makes each count last several input clocks.

The counter never reads the bus registers directly. At start it copies period, duty and duty polarity into a working copy, and it refreshes that copy only at a period boundary. Setting the hold bit suppresses the refresh. Software can therefore rewrite period, duty and polarity under the hold, and the three changes then take effect together at the first boundary after the hold is released. When a burst ends, the channel raises a sticky status flag and, if enabled, the interrupt line.

The controller has three states. IDLE moves to RUN on *start* (enabled, in burst or continuous mode). RUN moves back to IDLE on *stop* (enable cleared or a capture mode selected), and moves to HALT on *burst end* (the last period of a burst completes). HALT moves to IDLE on *release* (enable cleared).

Top module: `pwm_lock_chan`

## Requirements
- R1: After reset the output and the interrupt line are low, and every register reads zero.
- R2: Register addresses are control 0, period 1, duty 2, status 3 and interrupt enable 4. Period and duty read back the value last written. Control bit 0 is enable. Bits 2:1 are the mode (0 burst, 1 continuous). Bit 3 is the duty level and bit 4 is the stopped level.
- R3: In left alignment (control bit 5 = 0), a count runs from 0 to period-1, starting 0 the cycle after the enabling write lands. The output takes the duty level while count < duty and the opposite level otherwise. A period of 0 acts as 1.
- R4: A duty of 0 never shows the duty level, and a duty greater than or equal to the period shows it for the whole period.
- R5: In centre alignment (bit 5 = 1), the count folds to min(count, period-1-count). The output takes the duty level while the folded value is below duty/2.
- R6: While control bit 6 (hold) is set, no period boundary refreshes the working period, duty or duty level. The first boundary after the hold clears applies all three together.
- R7: In burst mode, bits 31:24 hold the number of periods minus one. After the last period the output returns to the stopped level and stays there, without restarting, until enable is cleared.
- R8: Bit 0 of the status register is set when a burst ends and cleared by writing 1 to it. When both happen in the same cycle, the set wins. The interrupt output equals status bit 0 AND interrupt-enable bit 0.
- R9: When enable is cleared, the output shows the stopped level in the cycle the write lands. The next start counts again from 0.
- R10: With control bit 9 set, each count lasts S input cycles, where S is bits 23:16 and a value of 0 means 256.
- R11: Modes 2 and 3 never start the counter, and the output holds the stopped level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
The end of a burst can land in the same cycle as a software write that clears the status bit. The bench places the clear write so that the bus captures it on the very edge where the last period of a one-period burst completes. The interrupt must still be high afterwards, and a second clear must then drop it. A second collision is between the release of the hold and the period boundary that follows it. The bench rewrites period, duty and polarity under the hold and lets one boundary pass while the hold is still set. It then checks the output cycle by cycle to confirm that the old waveform lasts exactly until the first boundary after the release.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int SHOT_W  = 8;
    localparam int SCALE_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS    = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd4;

    localparam int B_EN     = 0;
    localparam int B_MODE   = 1;
    localparam int B_DPOL   = 3;
    localparam int B_IPOL   = 4;
    localparam int B_CENTER = 5;
    localparam int B_LOCK   = 6;
    localparam int B_SCALED = 9;
    localparam int B_SCALE  = 16;
    localparam int B_SHOT   = 24;

    typedef enum logic [1:0] {
        MODE_BURST = 2'd0,
        MODE_CONT  = 2'd1,
        MODE_CAP   = 2'd2,
        MODE_RSV   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [SHOT_W-1:0]  shots_m1;
        logic [SCALE_W-1:0] scale;
        logic               scaled;
        logic               lock;
        logic               center;
        logic               ipol;
        logic               dpol;
        mode_e              mode;
        logic               en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.en       = w[B_EN];
        c.mode     = mode_e'(w[B_MODE +: 2]);
        c.dpol     = w[B_DPOL];
        c.ipol     = w[B_IPOL];
        c.center   = w[B_CENTER];
        c.lock     = w[B_LOCK];
        c.scaled   = w[B_SCALED];
        c.scale    = w[B_SCALE +: SCALE_W];
        c.shots_m1 = w[B_SHOT +: SHOT_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                    = '0;
        w[B_EN]              = c.en;
        w[B_MODE +: 2]       = c.mode;
        w[B_DPOL]            = c.dpol;
        w[B_IPOL]            = c.ipol;
        w[B_CENTER]          = c.center;
        w[B_LOCK]            = c.lock;
        w[B_SCALED]          = c.scaled;
        w[B_SCALE +: SCALE_W] = c.scale;
        w[B_SHOT +: SHOT_W]  = c.shots_m1;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              done_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic              irq_o
);

    logic sts_q;
    logic ien_q;
    logic clr_req;

    assign clr_req = bus_wr && (bus_addr == A_STS) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            period_o <= '0;
            duty_o   <= '0;
            ien_q    <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   ctrl_o   <= unpack_ctrl(bus_wdata);
                A_PERIOD: period_o <= bus_wdata[CNT_W-1:0];
                A_DUTY:   duty_o   <= bus_wdata[CNT_W-1:0];
                A_IEN:    ien_q    <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    // burst end has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (done_i)  sts_q <= 1'b1;
        else if (clr_req) sts_q <= 1'b0;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = pack_ctrl(ctrl_o);
            A_PERIOD: bus_rdata = REG_W'(period_o);
            A_DUTY:   bus_rdata = REG_W'(duty_o);
            A_STS:    bus_rdata = {{(REG_W-1){1'b0}}, sts_q};
            A_IEN:    bus_rdata = {{(REG_W-1){1'b0}}, ien_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = sts_q & ien_q;

    // R8
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> sts_q);

    // R8
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !done_i) |=> !sts_q);

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               scaled_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);

    localparam int DIV_W = SCALE_W + 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (scale_i == '0) ? DIV_W'(1 << SCALE_W) : DIV_W'(scale_i);
        tick_o = run_i && (!scaled_i || (div_cnt >= lim - DIV_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  div_cnt <= '0;
        else if (!run_i || !scaled_i) div_cnt <= '0;
        else if (tick_o)             div_cnt <= '0;
        else                         div_cnt <= div_cnt + DIV_W'(1);
    end

    // R10
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && scaled_i && tick_o) |=> (!tick_o || scale_i == 8'd1 || !scaled_i));

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             done_o,
    output logic             pwm_o
);

    run_state_e        state;
    run_state_e        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  act_period;
    logic [CNT_W-1:0]  act_duty;
    logic              act_dpol;
    logic [SHOT_W-1:0] shots_left;

    logic [CNT_W-1:0]  per_eff;
    logic [CNT_W-1:0]  last;
    logic [CNT_W-1:0]  half;
    logic [CNT_W-1:0]  fold;
    logic              mode_ok;
    logic              boundary;
    logic              burst_end;
    logic              start;
    logic              in_duty;

    always_comb begin
        mode_ok   = (ctrl_i.mode == MODE_BURST) || (ctrl_i.mode == MODE_CONT);
        per_eff   = (act_period == '0) ? CNT_W'(1) : act_period;
        last      = per_eff - CNT_W'(1);
        boundary  = tick_i && (cnt >= last);
        burst_end = boundary && (ctrl_i.mode == MODE_BURST) && (shots_left == '0);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (ctrl_i.en && mode_ok) nxt = ST_RUN;
            ST_RUN: begin
                if (!ctrl_i.en || !mode_ok) nxt = ST_IDLE;
                else if (burst_end)         nxt = ST_HALT;
            end
            ST_HALT: if (!ctrl_i.en) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign start = (state == ST_IDLE) && (nxt == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // counter and working copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_period <= '0;
            act_duty   <= '0;
            act_dpol   <= 1'b0;
            shots_left <= '0;
        end else if (start) begin
            cnt        <= '0;
            act_period <= period_i;
            act_duty   <= duty_i;
            act_dpol   <= ctrl_i.dpol;
            shots_left <= ctrl_i.shots_m1;
        end else if ((state == ST_RUN) && (nxt != ST_RUN)) begin
            cnt <= '0;
        end else if ((state == ST_RUN) && tick_i) begin
            if (boundary) begin
                cnt <= '0;
                if (!ctrl_i.lock) begin
                    act_period <= period_i;
                    act_duty   <= duty_i;
                    act_dpol   <= ctrl_i.dpol;
                end
                if ((ctrl_i.mode == MODE_BURST) && (shots_left != '0))
                    shots_left <= shots_left - SHOT_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        half    = per_eff >> 1;
        fold    = (cnt < half) ? cnt : (last - cnt);
        in_duty = (act_duty >= per_eff) ||
                  (ctrl_i.center ? (fold < (act_duty >> 1)) : (cnt < act_duty));
        run_o   = (state == ST_RUN);
        done_o  = (state == ST_RUN) && (nxt == ST_HALT);
        if ((state == ST_RUN) && ctrl_i.en && mode_ok)
            pwm_o = in_duty ? act_dpol : ~act_dpol;
        else
            pwm_o = ctrl_i.ipol;
    end

    // R9
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.en |=> (state != ST_RUN && cnt == '0));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN && $past(ctrl_i.lock)) |->
        (act_period == $past(act_period) && act_duty == $past(act_duty) &&
         act_dpol == $past(act_dpol)));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt <= last));

    // R7
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) != ST_HALT) |->
        ($past(ctrl_i.mode) == MODE_BURST && $past(shots_left) == '0));

    // R11
    cap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == MODE_CAP || ctrl_i.mode == MODE_RSV) |=> (state != ST_RUN));

endmodule

// File: rtl/pwm_lock_chan.sv
module pwm_lock_chan
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_o,
    output logic        irq_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] period_s;
    logic [CNT_W-1:0] duty_s;
    logic             tick;
    logic             run;
    logic             done;

    pwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_i    (done),
        .ctrl_o    (ctrl),
        .period_o  (period_s),
        .duty_o    (duty_s),
        .irq_o     (irq_o)
    );

    pwm_prescale scale_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .scaled_i (ctrl.scaled),
        .scale_i  (ctrl.scale),
        .tick_o   (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_i   (ctrl),
        .period_i (period_s),
        .duty_i   (duty_s),
        .tick_i   (tick),
        .run_o    (run),
        .done_o   (done),
        .pwm_o    (pwm_o)
    );

endmodule

// File: tb/pwm_lock_chan_tb_top.sv
module pwm_lock_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pwm_o;
    logic        irq_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    pwm_lock_chan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; write captured at the next posedge, returns at the following negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 pwm", {31'd0, pwm_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rd_chk("R1 ctrl", 3'd0, 32'd0);
        rd_chk("R1 period", 3'd1, 32'd0);
        rd_chk("R1 status", 3'd3, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_readback;
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'h0000_abcd);
        wr(3'd4, 32'h1);
        rd_chk("R2 period", 3'd1, 32'h1234_5678);
        rd_chk("R2 duty", 3'd2, 32'h0000_abcd);
        rd_chk("R2 ien", 3'd4, 32'h1);
        @(negedge clk);
        wr(3'd0, 32'hff03_0255);
        rd_chk("R2 ctrl", 3'd0, 32'hff03_0255);
        @(negedge clk);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_left;
        wr(3'd1, 32'd6);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            chk("R3 left", {31'd0, pwm_o}, {31'd0, ((c % 6) < 2)});
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_duty_edges;
        wr(3'd1, 32'd5);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk("R4 zero duty", {31'd0, pwm_o}, 32'd0);
        end
        wr(3'd0, 32'h0);
        wr(3'd2, 32'd7);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk("R4 full duty", {31'd0, pwm_o}, 32'd1);
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_center;
        wr(3'd1, 32'd10);
        wr(3'd2, 32'd4);
        wr(3'd0, 32'h0000_002B);
        for (int c = 0; c < 20; c++) begin
            int k;
            k = c % 10;
            @(negedge clk);
            chk("R5 center", {31'd0, pwm_o}, {31'd0, (k < 2 || k > 7)});
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_lock;
        wr(3'd1, 32'd8);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 36; c++) begin
            logic e;
            if (c == 11)      wr(3'd0, 32'h0000_004B);
            else if (c == 12) wr(3'd1, 32'd6);
            else if (c == 13) wr(3'd2, 32'd5);
            else if (c == 14) wr(3'd0, 32'h0000_0053);
            else if (c == 19) wr(3'd0, 32'h0000_0013);
            else              @(negedge clk);
            if (c < 24) e = ((c % 8) < 2);
            else        e = !(((c - 24) % 6) < 5);
            chk("R6 lock", {31'd0, pwm_o}, {31'd0, e});
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_burst;
        wr(3'd4, 32'h1);
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h0200_0009);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk("R7 burst", {31'd0, pwm_o}, {31'd0, (c < 12) && ((c % 4) < 1)});
            chk("R8 irq", {31'd0, irq_o}, {31'd0, (c >= 12)});
        end
        rd_chk("R8 status", 3'd3, 32'd1);
        @(negedge clk);
        wr(3'd3, 32'h1);
        chk("R8 clear", {31'd0, irq_o}, 32'd0);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R7 stays halted", {31'd0, pwm_o}, 32'd0);
            chk("R7 no new end", {31'd0, irq_o}, 32'd0);
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_collide;
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0000_0009);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R7 single period", {31'd0, pwm_o}, {31'd0, (c < 2)});
        end
        wr(3'd3, 32'h1);
        chk("R8 set beats clear", {31'd0, irq_o}, 32'd1);
        wr(3'd3, 32'h1);
        chk("R8 later clear", {31'd0, irq_o}, 32'd0);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_disable;
        wr(3'd1, 32'd5);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R9 pre", {31'd0, pwm_o}, {31'd0, (c < 2)});
        end
        wr(3'd0, 32'h0000_0010);
        chk("R9 stopped level", {31'd0, pwm_o}, 32'd1);
        wr(3'd0, 32'h0000_000B);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk("R9 restart", {31'd0, pwm_o}, {31'd0, ((c % 5) < 2)});
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_scaled;
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0003_020B);
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            chk("R10 scaled", {31'd0, pwm_o}, {31'd0, (((c / 3) % 4) < 2)});
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_capture;
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'h0000_0015);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R11 capture idle", {31'd0, pwm_o}, 32'd1);
        end
        wr(3'd0, 32'h0000_0017);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R11 mode 3 idle", {31'd0, pwm_o}, 32'd1);
        end
        wr(3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_left();
        t_duty_edges();
        t_center();
        t_lock();
        t_burst();
        t_collide();
        t_disable();
        t_scaled();
        t_capture();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule